// File: doc/BRIEF.md
# Exception Vector Write Guard

This block sits on the data path between a processor's load/store port and memory. It inspects every data access and stops any store that would touch the lowest 32 bytes of the address space, where the exception vectors live. The store never reaches memory, and the core receives an abort pulse instead. Loads from that region go through untouched, so handlers can still read the vectors while software is kept from changing them in place.

A second check is available for a legacy configuration that uses only 26 address bits. When the configuration input selects that mode, any access that starts at or above 64 MB is turned into an abort, whether it is a load or a store. A store caught this way is also kept from memory. The write enable to memory is combinational, so it is gated in the same cycle as the request. The abort is registered and appears one cycle later.

Top module: `vec_write_guard`

## Requirements
- R1: A valid store whose start address lies in 0x00..0x1F is kept from memory: `mem_we` is low in the same cycle. This holds for every size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R2: A valid store that begins near the top of the address space, and whose last byte wraps around into 0x00..0x1F, is also kept from memory.
- R3: Each store kept from memory by R1 or R2 makes `abort_pulse` high in exactly the cycle that follows the request, for that one cycle only.
- R4: A valid load (`req_write` = 0) from 0x00..0x1F raises no abort, and `mem_we` stays low.
- R5: With `legacy_cfg` = 1, any valid access whose start address is at or above 0x0400_0000 raises `abort_pulse` in the next cycle. This applies to loads and stores alike, and such a store also drives `mem_we` low.
- R6: With `legacy_cfg` = 0, stores above 64 MB that do not wrap into the vector area reach memory (`mem_we` = 1) and raise no abort.
- R7: A valid store that is neither in the vector area nor out of range drives `mem_we` high in the same cycle, and `abort_pulse` is low in the next cycle.
- R8: While `req_valid` is low, `mem_we` is low, and `abort_pulse` is low in the following cycle, whatever the other inputs are.
- R9: Synchronous reset clears `abort_pulse`. A request presented while `rst` is high produces no abort in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte start address |
| req_size | input | 2 | Size code: 0 = byte, 1 = half, 2 = word, 3 = double |
| legacy_cfg | input | 1 | 1 selects the 64 MB legacy address window |
| mem_we | output | 1 | Gated write enable to memory |
| abort_pulse | output | 1 | Data abort to the core, one cycle after the request |

## Verification
The only state in the block is the abort register. If that register is wrong, the fault shows on `abort_pulse` one cycle after the request that should have set it: a missing pulse, a stuck high level, or a pulse after an idle or reset cycle. Faults in the range or overlap decode show up even sooner, on `mem_we`, in the same cycle as the request. The bench checks both ports on every cycle. It places addresses around 0x1F/0x20, the top-of-space wrap and the 64 MB boundary, so that an off-by-one in any comparison shows within a single request.

// File: rtl/vwg_pkg.sv
package vwg_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   // offset from first to last byte of an access of the given size
   function automatic logic [3:0] last_offset(acc_size_e s);
      case (s)
         SZ_BYTE:  return 4'd0;
         SZ_HALF:  return 4'd1;
         SZ_WORD:  return 4'd3;
         default:  return 4'd7;
      endcase
   endfunction

endpackage

// File: rtl/vwg_span.sv
// Computes the last byte address of an access and whether it wrapped.
module vwg_span #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]     first_addr,
   input  vwg_pkg::acc_size_e    size,
   output logic [ADDR_W-1:0]     last_addr,
   output logic                  wrapped
);
   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum       = {1'b0, first_addr} + SUM_W'(vwg_pkg::last_offset(size));
      last_addr = sum[ADDR_W-1:0];
      wrapped   = sum[ADDR_W];
   end
endmodule

// File: rtl/vwg_vec_hit.sv
// Flags an access whose byte span touches the protected low region.
module vwg_vec_hit #(
   parameter int ADDR_W    = 32,
   parameter int VEC_BYTES = 32
) (
   input  logic [ADDR_W-1:0] first_addr,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic              wrapped,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(VEC_BYTES);

   logic start_in;
   logic tail_in;

   always_comb begin
      start_in = first_addr < LIMIT;
      tail_in  = wrapped && (last_addr < LIMIT);
      hit      = start_in || tail_in;
   end
endmodule

// File: rtl/vwg_range.sv
// Legacy window check; a parameter picks whether the comparator exists.
module vwg_range #(
   parameter int ADDR_W    = 32,
   parameter int SPAN_LOG2 = 26,
   parameter bit ENABLE    = 1'b1
) (
   input  logic [ADDR_W-1:0] first_addr,
   input  logic              legacy,
   output logic              out_of_range
);
   generate
      if (ENABLE) begin : g_check
         logic above;
         always_comb begin
            above        = |first_addr[ADDR_W-1:SPAN_LOG2];
            out_of_range = legacy && above;
         end
      end else begin : g_none
         assign out_of_range = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/vwg_abort_reg.sv
// Single-cycle abort register with synchronous clear.
module vwg_abort_reg (
   input  logic clk,
   input  logic rst,
   input  logic set,
   output logic pulse
);
   always_ff @(posedge clk) begin
      if (rst) pulse <= 1'b0;
      else     pulse <= set;
   end
endmodule

// File: rtl/vec_write_guard.sv
module vec_write_guard #(
   parameter int ADDR_W       = 32,
   parameter int VEC_BYTES    = 32,
   parameter int SPAN_LOG2    = 26,
   parameter bit RANGE_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              legacy_cfg,
   output logic              mem_we,
   output logic              abort_pulse
);
   // elaboration checks on the parameter set
   generate
      if (SPAN_LOG2 >= ADDR_W || SPAN_LOG2 < 1) begin : g_bad_span
         $error("vec_write_guard: SPAN_LOG2 must be below ADDR_W");
      end
      if (VEC_BYTES < 1 || (ADDR_W < 32 && VEC_BYTES >= (1 << ADDR_W))) begin : g_bad_vec
         $error("vec_write_guard: VEC_BYTES out of address range");
      end
      if (SPAN_LOG2 > 0 && VEC_BYTES > (1 << SPAN_LOG2)) begin : g_bad_mix
         $error("vec_write_guard: vector area exceeds legacy window");
      end
   endgenerate

   logic [ADDR_W-1:0] last_addr;
   logic              wrapped;
   logic              vec_hit;
   logic              range_hit;
   logic              store_blocked;
   logic              abort_set;

   vwg_span #(.ADDR_W(ADDR_W)) u_span (
      .first_addr (req_addr),
      .size       (vwg_pkg::acc_size_e'(req_size)),
      .last_addr  (last_addr),
      .wrapped    (wrapped)
   );

   vwg_vec_hit #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES)) u_vec (
      .first_addr (req_addr),
      .last_addr  (last_addr),
      .wrapped    (wrapped),
      .hit        (vec_hit)
   );

   vwg_range #(.ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .ENABLE(RANGE_ENABLE)) u_range (
      .first_addr   (req_addr),
      .legacy       (legacy_cfg),
      .out_of_range (range_hit)
   );

   always_comb begin
      store_blocked = vec_hit || range_hit;
      mem_we        = req_valid && req_write && !store_blocked;
      abort_set     = req_valid && ((req_write && vec_hit) || range_hit);
   end

   vwg_abort_reg u_abort (
      .clk   (clk),
      .rst   (rst),
      .set   (abort_set),
      .pulse (abort_pulse)
   );
endmodule

// File: rtl/vwg_chk.sv
module vwg_chk #(
   parameter int ADDR_W    = 32,
   parameter int VEC_BYTES = 32,
   parameter int SPAN_LOG2 = 26
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              legacy_cfg,
   input logic              mem_we,
   input logic              abort_pulse
);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(VEC_BYTES);

   logic low_area;
   logic high_area;
   assign low_area  = req_addr < LIMIT;
   assign high_area = |req_addr[ADDR_W-1:SPAN_LOG2];

   AST_VEC_STORE_GATED: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_write && low_area |-> !mem_we); // R1

   AST_VEC_STORE_ABORT: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_write && low_area |=> abort_pulse); // R3

   AST_VEC_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
      req_valid && !req_write && low_area |=> !abort_pulse); // R4

   AST_LEGACY_ABORT: assert property (@(posedge clk) disable iff (rst)
      req_valid && legacy_cfg && high_area |=> abort_pulse); // R5

   AST_LEGACY_NO_WE: assert property (@(posedge clk) disable iff (rst)
      legacy_cfg && high_area |-> !mem_we); // R5

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !abort_pulse); // R8

   AST_WE_NEEDS_STORE: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> req_valid && req_write); // R8

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> !abort_pulse); // R9
endmodule

bind vec_write_guard vwg_chk #(
   .ADDR_W    (ADDR_W),
   .VEC_BYTES (VEC_BYTES),
   .SPAN_LOG2 (SPAN_LOG2)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .legacy_cfg  (legacy_cfg),
   .mem_we      (mem_we),
   .abort_pulse (abort_pulse)
);

// File: tb/sim_vec_write_guard.sv
`timescale 1ns/1ps
module sim_vec_write_guard;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        legacy_cfg = 1'b0;
   logic        mem_we;
   logic        abort_pulse;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vec_write_guard u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .legacy_cfg(legacy_cfg),
      .mem_we(mem_we), .abort_pulse(abort_pulse)
   );

   function automatic bit f_vec(logic [31:0] a, logic [1:0] s);
      logic [32:0] e;
      e = {1'b0, a} + 33'((1 << s) - 1);
      return (a < 32'h20) || (e[32] && (e[31:0] < 32'h20));
   endfunction

   function automatic bit f_rng(logic [31:0] a, bit l);
      return l && (a >= 32'h0400_0000);
   endfunction

   function automatic bit f_we(bit v, bit w, logic [31:0] a, logic [1:0] s, bit l);
      return v && w && !f_vec(a, s) && !f_rng(a, l);
   endfunction

   function automatic bit f_ab(bit v, bit w, logic [31:0] a, logic [1:0] s, bit l);
      return v && ((w && f_vec(a, s)) || f_rng(a, l));
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // called at a negedge; leaves at the next negedge
   task automatic apply(bit v, bit w, logic [31:0] a, logic [1:0] s, bit l, string req);
      bit exp_ab;
      req_valid = v; req_write = w; req_addr = a; req_size = s; legacy_cfg = l;
      #1;
      check(req, "mem_we", int'(mem_we), int'(f_we(v, w, a, s, l)));
      exp_ab = rst ? 1'b0 : f_ab(v, w, a, s, l);
      @(negedge clk);
      check(req, "abort_pulse", int'(abort_pulse), int'(exp_ab));
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      @(negedge clk);
      check("R9", "abort after reset", int'(abort_pulse), 0);
      // R9: offending store during reset yields no abort
      apply(1, 1, 32'h0000_0004, 2, 0, "R9");
      rst = 1'b0;

      // R1: every size at vector edges
      for (int s = 0; s < 4; s++) begin
         apply(1, 1, 32'h0000_0000, 2'(s), 0, "R1");
         apply(1, 1, 32'h0000_001F, 2'(s), 0, "R1");
      end
      apply(1, 1, 32'h0000_0020, 2, 0, "R7");
      // R2: wrap into vector area
      apply(1, 1, 32'hFFFF_FFFC, 3, 0, "R2");
      apply(1, 1, 32'hFFFF_FFFF, 1, 0, "R2");
      apply(1, 1, 32'hFFFF_FFFC, 2, 0, "R7");
      // R3: back-to-back blocked stores then clean store
      apply(1, 1, 32'h0000_0010, 0, 0, "R3");
      apply(1, 1, 32'h0000_0018, 2, 0, "R3");
      apply(1, 1, 32'h0000_1000, 2, 0, "R3");
      // R4: loads in vector area
      apply(1, 0, 32'h0000_0000, 2, 0, "R4");
      apply(1, 0, 32'h0000_001C, 3, 1, "R4");
      // R5: legacy window boundary
      apply(1, 0, 32'h0400_0000, 0, 1, "R5");
      apply(1, 1, 32'h0400_0000, 2, 1, "R5");
      apply(1, 1, 32'h03FF_FFFC, 2, 1, "R5");
      apply(1, 1, 32'hFFFF_0000, 2, 1, "R5");
      // R6: same addresses without legacy
      apply(1, 1, 32'h0400_0000, 2, 0, "R6");
      apply(1, 0, 32'hFFFF_0000, 2, 0, "R6");
      // R8: idle with offending fields
      apply(0, 1, 32'h0000_0000, 2, 1, "R8");
      apply(0, 0, 32'hF000_0000, 2, 1, "R8");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a;
         int cat;
         cat = int'($urandom_range(0, 3));
         case (cat)
            0: a = 32'($urandom_range(0, 63));
            1: a = 32'hFFFF_FFF0 + 32'($urandom_range(0, 15));
            2: a = 32'h03FF_FFF0 + 32'($urandom_range(0, 31));
            default: a = $urandom;
         endcase
         apply(bit'($urandom_range(0, 7) != 0), bit'($urandom_range(0, 1)), a,
               2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), "R7");
      end

      // R9: reset mid-run after a blocked store
      apply(1, 1, 32'h0000_0008, 0, 0, "R3");
      rst = 1'b1;
      apply(1, 1, 32'h0000_0008, 0, 0, "R9");
      rst = 1'b0;
      apply(0, 0, 32'h0, 0, 0, "R8");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule